// File: doc/BRIEF.md
# Run-Time Configurable Serial Frame Transmitter

This block serializes one byte per request onto a single output line that idles high. Each frame starts with a low start bit. The data bits follow, least-significant first. An optional parity bit comes next, and the frame ends with one or two high stop bits. Four run-time inputs set the frame format:

- the data width, from 5 to 8 bits;
- the number of stop bits;
- whether a parity bit is sent;
- odd or even parity.

A receiver set to the same values can decode the frame.

Bit timing comes from an external tick that runs at sixteen times the baud rate. The tick may be held high for several clock cycles. The block detects its rising edge and counts sixteen edges per bit. A write strobe with a byte starts a frame only while the block is not busy. The byte and all format inputs are captured at that moment, so later changes do not affect the frame in progress.

Top module: `uart_frame_tx`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `txd` is 1 and `busy` is 0.
- R2: If `wr_en` is 1 at a clock edge while `busy` is 0, a frame starts: after that edge `busy` is 1 and `txd` drives the start bit 0.
- R3: The data bits follow the start bit, least-significant bit first. Their number is `data_bits`, with values below 5 treated as 5 and values above 8 treated as 8.
- R4: When `parity_en` is 1, one parity bit follows the last data bit. `parity_odd`=0 makes the count of ones over the sent data bits plus the parity bit even. `parity_odd`=1 makes that count odd. Data bits that are not sent do not affect parity.
- R5: When `parity_en` is 0, no parity slot exists, and the first stop bit directly follows the last data bit.
- R6: The stop bits are 1. There is one stop bit when `stop_two` is 0 and two when it is 1.
- R7: Each bit ends on the 16th rising edge of `tick16` counted from the start of that bit. The first bit starts at the accepting clock edge. A tick held high for several cycles counts once.
- R8: `busy` stays 1 until the last stop bit ends. After that, `busy` is 0 and `txd` is 1.
- R9: While `busy` is 1, `wr_en` is ignored and changes to `wr_data`, `data_bits`, `stop_two`, `parity_en` or `parity_odd` do not alter the frame. No new frame follows the current one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | Timing tick at 16x baud rate; may be a multi-cycle level |
| wr_en | input | 1 | Frame request strobe |
| wr_data | input | 8 | Byte to send |
| data_bits | input | 4 | Data bits per frame (5..8, clamped) |
| stop_two | input | 1 | 0: one stop bit, 1: two stop bits |
| parity_en | input | 1 | 1: append a parity bit |
| parity_odd | input | 1 | 0: even parity, 1: odd parity |
| busy | output | 1 | High while a frame is on the line |
| txd | output | 1 | Serial output, idle high |

## Verification
The start bit and `busy` appear at the output one clock after the accepting edge. Every later bit changes one clock after the `tick16` rising edge that completes its sixteenth count. The bench drives all inputs, including the tick, on falling clock edges and counts tick rising edges from the accepting write. It samples `txd` two clocks after the eighth tick edge of each bit, which is the middle of the bit. It checks that `busy` has fallen two clocks after the final tick edge of the last stop bit. The tick is held high for three clocks in every six, so a design that counts tick levels instead of edges produces bits of the wrong length and fails the mid-bit samples.

// File: rtl/uart_frame_tx.sv
module uart_frame_tx #(
  parameter int OVERSAMPLE = 16,
  parameter int MAX_BITS   = 8,
  parameter int MIN_BITS   = 5,
  parameter int LEN_W      = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic                wr_en,
  input  logic [MAX_BITS-1:0] wr_data,
  input  logic [LEN_W-1:0]    data_bits,
  input  logic                stop_two,
  input  logic                parity_en,
  input  logic                parity_odd,
  output logic                busy,
  output logic                txd
);
  localparam int CW = $clog2(OVERSAMPLE);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t                 st;
  logic                tick_q;
  logic [CW-1:0]       tcnt;
  logic [MAX_BITS-1:0] sh;
  logic [LEN_W-1:0]    len_q, bcnt, len_sel;
  logic                par_q, two_q, pen_q;
  logic [MAX_BITS-1:0] masked;
  logic                par_calc;

  wire tick_pulse = tick16 & ~tick_q;
  wire bit_end    = tick_pulse && (tcnt == CW'(OVERSAMPLE - 1));
  wire accept     = (st == S_IDLE) && wr_en;

  assign busy = (st != S_IDLE);

  always_comb begin
    if (data_bits < LEN_W'(MIN_BITS))      len_sel = LEN_W'(MIN_BITS);
    else if (data_bits > LEN_W'(MAX_BITS)) len_sel = LEN_W'(MAX_BITS);
    else                                   len_sel = data_bits;
    for (int i = 0; i < MAX_BITS; i++)
      masked[i] = wr_data[i] && (LEN_W'(i) < len_sel);
    par_calc = (^masked) ^ parity_odd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick16;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      txd   <= 1'b1;
      tcnt  <= '0;
      sh    <= '0;
      len_q <= LEN_W'(MAX_BITS);
      bcnt  <= '0;
      par_q <= 1'b0;
      two_q <= 1'b0;
      pen_q <= 1'b0;
    end else begin
      if (accept || bit_end)  tcnt <= '0;
      else if (tick_pulse)    tcnt <= tcnt + CW'(1);
      case (st)
        S_IDLE: if (wr_en) begin
          st    <= S_START;
          txd   <= 1'b0;
          sh    <= wr_data;
          len_q <= len_sel;
          par_q <= par_calc;
          two_q <= stop_two;
          pen_q <= parity_en;
          bcnt  <= '0;
        end
        S_START: if (bit_end) begin
          st   <= S_DATA;
          txd  <= sh[0];
          sh   <= sh >> 1;
          bcnt <= '0;
        end
        S_DATA: if (bit_end) begin
          if (bcnt == len_q - LEN_W'(1)) begin
            bcnt <= '0;
            if (pen_q) begin
              st  <= S_PAR;
              txd <= par_q;
            end else begin
              st  <= S_STOP;
              txd <= 1'b1;
            end
          end else begin
            bcnt <= bcnt + LEN_W'(1);
            txd  <= sh[0];
            sh   <= sh >> 1;
          end
        end
        S_PAR: if (bit_end) begin
          st   <= S_STOP;
          txd  <= 1'b1;
          bcnt <= '0;
        end
        S_STOP: if (bit_end) begin
          if (two_q && bcnt == '0) bcnt <= LEN_W'(1);
          else                     st   <= S_IDLE;
          txd <= 1'b1;
        end
        default: begin
          st  <= S_IDLE;
          txd <= 1'b1;
        end
      endcase
    end
  end

  // R2: an accepted request puts the start bit on the line
  p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (busy && !txd));

  // R8: the line is high whenever no frame is in flight
  p_idle_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);

  // R6: stop slots always drive 1
  p_stop_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP) |-> txd);

  // R7: during a frame the line only moves on a completed bit period
  p_hold_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> ($stable(txd) && busy));

  // R9: captured format cannot change while busy
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(len_q) && $stable(par_q) && $stable(two_q) && $stable(pen_q)));

  // R3: the data-bit counter never passes the captured width
  p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA) |-> (bcnt < len_q));
endmodule

// File: tb/uart_frame_tx_test.sv
module uart_frame_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick16 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [3:0] data_bits = 4'd8;
  logic       stop_two = 1'b0, parity_en = 1'b0, parity_odd = 1'b0;
  logic       busy, txd;

  int errors = 0, checks = 0, cycles = 0, rises = 0, phase = 0;

  always #4 clk = ~clk;

  uart_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en), .wr_data(wr_data),
    .data_bits(data_bits), .stop_two(stop_two), .parity_en(parity_en),
    .parity_odd(parity_odd), .busy(busy), .txd(txd));

  // {data[19:12], data_bits[11:8], stop_two[7], parity_en[6], parity_odd[5], exp_parity[4], frame_bits[3:0]}
  localparam logic [19:0] VEC [9] = '{
    20'hA580A, 20'h3C8CC, 20'h3C87B, 20'hFF558, 20'hE15E9,
    20'h5A709, 20'h806CA, 20'h01F0A, 20'h1F268 };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    cycles++;
    phase = (phase + 1) % 6;
    tick16 = (phase < 3);
    if (phase == 0) rises++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic wait_rises(input int target);
    while (rises < target) cyc();
    cyc(); cyc();
  endtask

  task automatic run_frame(input logic [19:0] v, input bit disturb);
    logic [7:0] d;
    int n, total;
    logic exp_b;
    string tag;
    d = v[19:12];
    n = (v[11:8] < 5) ? 5 : (v[11:8] > 8) ? 8 : int'(v[11:8]);
    total = int'(v[3:0]);
    cyc();
    wr_en = 1'b1; wr_data = d; data_bits = v[11:8];
    stop_two = v[7]; parity_en = v[6]; parity_odd = v[5];
    rises = 0;
    cyc();
    wr_en = 1'b0;
    check("R2 busy after accept", {7'd0, busy}, 8'd1);
    for (int b = 0; b < total; b++) begin
      wait_rises(16 * b + 8);
      if (b == 0) begin exp_b = 1'b0; tag = "R2 start bit"; end
      else if (b <= n) begin exp_b = d[b-1]; tag = "R3 data bit"; end
      else if (v[6] && b == n + 1) begin exp_b = v[4]; tag = "R4 parity bit"; end
      else if (!v[6] && b == n + 1) begin exp_b = 1'b1; tag = "R5 stop after data"; end
      else begin exp_b = 1'b1; tag = "R6 stop bit"; end
      check(tag, {7'd0, txd}, {7'd0, exp_b});
      check("R8 busy mid-frame", {7'd0, busy}, 8'd1);
      if (disturb && b == 3) begin
        wr_en = 1'b1; wr_data = ~d; data_bits = 4'd5;
        stop_two = ~v[7]; parity_en = ~v[6]; parity_odd = ~v[5];
        cyc();
        wr_en = 1'b0;
      end
    end
    wait_rises(16 * total);
    check("R7/R8 frame end busy low", {7'd0, busy}, 8'd0);
    check("R8 line high after frame", {7'd0, txd}, 8'd1);
    if (disturb) begin
      wait_rises(16 * total + 40);
      check("R9 ignored write starts nothing", {6'd0, busy, txd}, 8'd1);
    end
  endtask

  initial begin
    // R1: reset state
    repeat (4) cyc();
    check("R1 txd in reset", {7'd0, txd}, 8'd1);
    check("R1 busy in reset", {7'd0, busy}, 8'd0);
    rst_n = 1'b1;
    repeat (3) cyc();
    check("R1 idle after reset", {6'd0, busy, txd}, 8'd1);

    // R2: main vectors
    for (int i = 0; i < 9; i++) run_frame(VEC[i], 1'b0);

    // R9: mid-frame write and format changes ignored
    run_frame(VEC[2], 1'b1);

    // R1: asynchronous reset in mid-frame
    cyc();
    wr_en = 1'b1; wr_data = 8'h00; data_bits = 4'd8;
    stop_two = 1'b0; parity_en = 1'b0; parity_odd = 1'b0;
    rises = 0;
    cyc();
    wr_en = 1'b0;
    wait_rises(16 * 2 + 8);
    check("R3 data zero before reset", {7'd0, txd}, 8'd0);
    rst_n = 1'b0;
    #1;
    check("R1 async reset txd", {7'd0, txd}, 8'd1);
    check("R1 async reset busy", {7'd0, busy}, 8'd0);
    cyc();
    rst_n = 1'b1;
    repeat (3) cyc();
    run_frame(VEC[3], 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule